// File: doc/BRIEF.md
# Locked Command Mailbox Controller

This block is a register-mapped mailbox through which a host hands one command and its payload to an execution agent. The host reaches it over a 32-bit register bus that has separate read and write strobes, a byte address and write data. Ownership comes from a read of the lock register: the read returns zero when the mailbox was free, and that same read claims it. The owner then walks a tracked phase machine. It writes the command word, then the payload length in bytes, then pushes payload words one at a time into the data-in port, and finally triggers execution.

An internal responder stands in for the execution agent. It accepts the command, holds a busy result for a fixed number of cycles, and then reports completion or failure. The outcome depends only on a subtractive byte checksum that travels as the first payload word. The responder does no cryptographic work. The payload can be read back through the data-out port. Writing zero to the execute register, or writing the unlock register, returns the mailbox to idle. Writes made out of order move it to a sticky error state.

Top module: `cmd_mailbox`

## Requirements
- R1: A read of the lock register (byte address 0x00) returns 0 when the mailbox is free, and the same read takes ownership. While the mailbox is owned, every lock read returns 1 and changes nothing. Whenever the phase state is not idle, the mailbox is owned.
- R2: The status register (0x1C) reads {22'b0, owned, phase[2:0], 2'b0, result[3:0]}. The owned flag is bit 9, the phase is bits 8:6 and the result is bits 3:0. Phase codes: 0 idle, 1 ready for command, 2 ready for length, 3 ready for data, 4 executing on the agent side, 5 executing on the host side, 6 error. Result codes: 0 busy, 2 complete, 3 failure. After reset the status register reads 0.
- R3: Taking the lock gives phase 1. Writing the command register (0x08) in phase 1 gives phase 2. Writing the length register (0x0C) in phase 2 gives phase 3. Both registers read back the value written. The user register (0x04) holds any value the owner writes.
- R4: A length write larger than DEPTH*4 bytes moves the phase to error.
- R5: A write to data-in (0x10) after the received byte count (4 per word pushed) has reached the declared length moves the phase to error.
- R6: Writing execute (0x18) with bit 0 set in phase 3 before the received byte count reaches the declared length moves the phase to error.
- R7: A command, length or data-in write, or an execute write with bit 0 set, made in any phase other than its own moves the phase to error.
- R8: An accepted execute moves the phase to 4 with result 0 for BUSY_CYCLES cycles. After that the phase becomes 5. Reading execute returns 1 while the phase is 4 or 5.
- R9: At the end of the busy time the result becomes 2 if the first payload word plus the bytes of the command word plus the later payload bytes sums to 0 modulo 2^32, and 3 otherwise.
- R10: Bytes of the last payload word that lie at or beyond the declared length are left out of the checksum.
- R11: While the mailbox is owned, writing execute with bit 0 clear, or writing the unlock register (0x20) with any value, gives phase 0, not owned, result 0. This applies from every phase, including error.
- R12: Writes while the mailbox is not owned change nothing.
- R13: Reads of data-out (0x14) by the owner return the payload words in push order, starting again at the first word after each acquisition. A read past the last word pushed returns 0 and does not advance.
- R14: In the error phase only the release writes of R11 change the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe; has priority over host_rd |
| host_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| host_addr | input | 6 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the same cycle as host_rd |

## Verification
The checksum path is tried with three payloads. The first is a full 196-byte signature-verify payload whose checksum is correct. The second is the same payload with the checksum off by one, which separates a complete result from a failure. The third is a 10-byte payload whose last word carries nonzero bytes beyond the declared length, which shows whether trailing bytes are masked. The sequencing logic is tried with an oversized length, an extra data push, an early execute and a command written in the data phase. Each should reach the error phase and stay there until a release write. Writes made without the lock and repeated lock reads separate the ownership rules from the phase rules.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CMD      = 3'd1,
    PH_LEN      = 3'd2,
    PH_DATA     = 3'd3,
    PH_EXEC_AGT = 3'd4,
    PH_EXEC_HST = 3'd5,
    PH_ERR      = 3'd6
  } phase_e;

  typedef enum logic [3:0] {
    RES_BUSY = 4'd0,
    RES_RDY  = 4'd1,
    RES_DONE = 4'd2,
    RES_FAIL = 4'd3
  } result_e;

  localparam logic [5:0] A_LOCK   = 6'h00;
  localparam logic [5:0] A_USER   = 6'h04;
  localparam logic [5:0] A_CMD    = 6'h08;
  localparam logic [5:0] A_LEN    = 6'h0C;
  localparam logic [5:0] A_DIN    = 6'h10;
  localparam logic [5:0] A_DOUT   = 6'h14;
  localparam logic [5:0] A_EXEC   = 6'h18;
  localparam logic [5:0] A_STS    = 6'h1C;
  localparam logic [5:0] A_UNLOCK = 6'h20;

  // Sum of the lowest nb bytes of a word (nb in 0..4).
  function automatic logic [31:0] byte_sum(input logic [31:0] w, input logic [2:0] nb);
    logic [31:0] acc;
    acc = '0;
    for (int b = 0; b < 4; b++) begin
      if (3'(b) < nb) acc = acc + {24'b0, w[8*b +: 8]};
    end
    return acc;
  endfunction

endpackage

// File: rtl/mbx_payload_store.sv
module mbx_payload_store #(
  parameter int DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [31:0]                 push_word,
  input  logic                        pop,
  output logic [31:0]                 pop_word,
  output logic [$clog2(DEPTH):0]      count
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = IDXW + 1;

  logic [31:0]     mem [DEPTH];
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] rd_q, rd_d;
  logic            rd_avail;

  assign rd_avail = (rd_q < cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    rd_d  = rd_q;
    if (clr) begin
      cnt_d = '0;
      rd_d  = '0;
    end else begin
      if (push) cnt_d = cnt_q + CNTW'(1);
      if (pop && rd_avail) rd_d = rd_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
    end
  end

  // Storage array without reset; contents only read below the fill count.
  always_ff @(posedge clk) begin
    if (push && !clr) mem[cnt_q[IDXW-1:0]] <= push_word;
  end

  assign pop_word = rd_avail ? mem[rd_q[IDXW-1:0]] : 32'h0;
  assign count    = cnt_q;

endmodule

// File: rtl/mbx_csum_acc.sv
module mbx_csum_acc
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_cmd,
  input  logic [31:0] cmd_word,
  input  logic        add_en,
  input  logic        add_whole,
  input  logic [31:0] add_word,
  input  logic [2:0]  add_nbytes,
  output logic        sum_zero
);
  logic [31:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (load_cmd)
      sum_d = byte_sum(cmd_word, 3'd4);
    else if (add_en)
      sum_d = sum_q + (add_whole ? add_word : byte_sum(add_word, add_nbytes));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_zero = (sum_q == 32'h0);

endmodule

// File: rtl/mbx_busy_timer.sv
module mbx_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign done = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = CW'(BUSY_CYCLES - 1);
      run_d = 1'b1;
    end else if (abort || done) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [5:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int          CNTW    = $clog2(DEPTH) + 1;
  localparam logic [31:0] LEN_MAX = 32'(DEPTH * 4);

  phase_e      state_q, state_d;
  result_e     result_q, result_d;
  logic        lock_q, lock_d;
  logic [31:0] cmd_q, len_q, user_q;

  logic            rd_en, lock_grab, release_req, own_wr;
  logic            cmd_we, len_we, user_we, push, exec_start;
  logic [CNTW-1:0] wr_count;
  logic [31:0]     recv_bytes, remaining;
  logic            len_full;
  logic [2:0]      push_nbytes;
  logic [31:0]     pop_word;
  logic            sum_zero, timer_done, timer_abort;

  assign rd_en       = host_rd && !host_wr;
  assign own_wr      = host_wr && lock_q;
  assign lock_grab   = rd_en && (host_addr == A_LOCK) && !lock_q;
  assign release_req = own_wr &&
                       (((host_addr == A_EXEC) && !host_wdata[0]) || (host_addr == A_UNLOCK));

  assign recv_bytes  = {{(30-CNTW){1'b0}}, wr_count, 2'b00};
  assign len_full    = (recv_bytes >= len_q);
  assign remaining   = len_q - recv_bytes;
  assign push_nbytes = (remaining >= 32'd4) ? 3'd4 : remaining[2:0];

  // Phase sequencing
  always_comb begin
    state_d    = state_q;
    result_d   = result_q;
    lock_d     = lock_q;
    cmd_we     = 1'b0;
    len_we     = 1'b0;
    push       = 1'b0;
    exec_start = 1'b0;
    if (lock_grab) begin
      lock_d   = 1'b1;
      state_d  = PH_CMD;
      result_d = RES_BUSY;
    end else if (own_wr) begin
      if (release_req) begin
        lock_d   = 1'b0;
        state_d  = PH_IDLE;
        result_d = RES_BUSY;
      end else if (state_q != PH_ERR) begin
        unique case (host_addr)
          A_CMD: begin
            if (state_q == PH_CMD) begin
              cmd_we  = 1'b1;
              state_d = PH_LEN;
            end else state_d = PH_ERR;
          end
          A_LEN: begin
            if (state_q == PH_LEN && host_wdata <= LEN_MAX) begin
              len_we  = 1'b1;
              state_d = PH_DATA;
            end else state_d = PH_ERR;
          end
          A_DIN: begin
            if (state_q == PH_DATA && !len_full) push = 1'b1;
            else state_d = PH_ERR;
          end
          A_EXEC: begin
            if (state_q == PH_DATA && len_full) begin
              exec_start = 1'b1;
              state_d    = PH_EXEC_AGT;
              result_d   = RES_BUSY;
            end else state_d = PH_ERR;
          end
          default: ;
        endcase
      end
    end
    if (state_q == PH_EXEC_AGT && state_d == PH_EXEC_AGT && timer_done) begin
      state_d  = PH_EXEC_HST;
      result_d = sum_zero ? RES_DONE : RES_FAIL;
    end
  end

  assign user_we     = own_wr && (host_addr == A_USER);
  assign timer_abort = (state_d != PH_EXEC_AGT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      result_q <= RES_BUSY;
      lock_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
      lock_q   <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      len_q  <= '0;
      user_q <= '0;
    end else begin
      if (cmd_we)  cmd_q  <= host_wdata;
      if (len_we)  len_q  <= host_wdata;
      if (user_we) user_q <= host_wdata;
    end
  end

  mbx_payload_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (lock_grab),
    .push      (push),
    .push_word (host_wdata),
    .pop       (rd_en && (host_addr == A_DOUT) && lock_q),
    .pop_word  (pop_word),
    .count     (wr_count)
  );

  mbx_csum_acc u_csum (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_cmd   (cmd_we),
    .cmd_word   (host_wdata),
    .add_en     (push),
    .add_whole  (wr_count == '0),
    .add_word   (host_wdata),
    .add_nbytes (push_nbytes),
    .sum_zero   (sum_zero)
  );

  mbx_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (exec_start),
    .abort (timer_abort),
    .done  (timer_done)
  );

  // Read mux
  always_comb begin
    host_rdata = '0;
    if (rd_en) begin
      unique case (host_addr)
        A_LOCK: host_rdata = {31'b0, lock_q};
        A_USER: host_rdata = user_q;
        A_CMD:  host_rdata = cmd_q;
        A_LEN:  host_rdata = len_q;
        A_DOUT: host_rdata = pop_word;
        A_EXEC: host_rdata = {31'b0, (state_q == PH_EXEC_AGT) || (state_q == PH_EXEC_HST)};
        A_STS:  host_rdata = {22'b0, lock_q, state_q, 2'b0, result_q};
        default: host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr,
  input logic                   rel_req,
  input logic [2:0]             state,
  input logic [3:0]             result,
  input logic                   lock_held,
  input logic [$clog2(DEPTH):0] wcount
);
  AST_OWNED_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0) |-> lock_held); // R1

  AST_BUSY_WHILE_AGENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4) |-> (result == 4'd0)); // R8

  AST_FINAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> (result == 4'd2 || result == 4'd3)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wcount) <= DEPTH)); // R5

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req |=> (state == 3'd0 && !lock_held && result == 4'd0)); // R11

  AST_UNOWNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !lock_held) |=> (state == 3'd0 && !lock_held)); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && !rel_req) |=> (state == 3'd6)); // R14
endmodule

bind cmd_mailbox mbx_checker #(.DEPTH(DEPTH)) u_mbx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .rel_req   (release_req),
  .state     (state_q),
  .result    (result_q),
  .lock_held (lock_q),
  .wcount    (wr_count)
);

// File: tb/cmd_mailbox_tb_top.sv
`timescale 1ns/1ps
module cmd_mailbox_tb_top;
  localparam int DEPTH = 64;
  localparam int BUSY  = 8;
  localparam logic [5:0] LOCK = 6'h00, USER = 6'h04, CMD = 6'h08, LEN = 6'h0C,
                         DIN = 6'h10, DOUT = 6'h14, EXEC = 6'h18, STS = 6'h1C, UNLK = 6'h20;
  localparam logic [31:0] SIGCMD = 32'h53494756;

  logic clk, rst_n, host_wr, host_rd;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;

  int n_checks = 0, n_errors = 0;

  cmd_mailbox #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  int          m_state, m_lock, m_result, m_rd, m_left;
  logic [31:0] m_cmd, m_len, m_user;
  logic [31:0] m_words[$];

  function automatic logic [31:0] model_sum();
    logic [31:0] s = 0;
    for (int b = 0; b < 4; b++) s += 32'(m_cmd[8*b +: 8]);
    for (int i = 0; i < m_words.size(); i++) begin
      if (i == 0) s += m_words[0];
      else for (int b = 0; b < 4; b++)
        if (32'(4*i + b) < m_len) s += 32'(m_words[i][8*b +: 8]);
    end
    return s;
  endfunction

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    case (a)
      LOCK: return 32'(m_lock);
      USER: return m_user;
      CMD:  return m_cmd;
      LEN:  return m_len;
      DOUT: return (m_rd < m_words.size()) ? m_words[m_rd] : 32'h0;
      EXEC: return (m_state == 4 || m_state == 5) ? 32'h1 : 32'h0;
      STS:  return 32'((m_lock << 9) | (m_state << 6) | m_result);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step(input bit wr, input bit rd, input logic [5:0] a, input logic [31:0] d);
    int prev = m_state;
    bit started = 0;
    if (wr) begin
      if (m_lock != 0) begin
        if ((a == EXEC && !d[0]) || a == UNLK) begin
          m_lock = 0; m_state = 0; m_result = 0;
        end else begin
          if (a == USER) m_user = d;
          if (m_state != 6) begin
            case (a)
              CMD:  if (m_state == 1) begin m_cmd = d; m_state = 2; end else m_state = 6;
              LEN:  if (m_state == 2 && d <= 32'(DEPTH*4)) begin m_len = d; m_state = 3; end
                    else m_state = 6;
              DIN:  if (m_state == 3 && 32'(m_words.size()*4) < m_len) m_words.push_back(d);
                    else m_state = 6;
              EXEC: if (m_state == 3 && 32'(m_words.size()*4) >= m_len) begin
                      m_state = 4; m_result = 0; m_left = BUSY; started = 1;
                    end else m_state = 6;
              default: ;
            endcase
          end
        end
      end
    end else if (rd) begin
      if (a == LOCK && m_lock == 0) begin
        m_lock = 1; m_state = 1; m_result = 0; m_words.delete(); m_rd = 0;
      end else if (a == DOUT && m_lock != 0 && m_rd < m_words.size()) m_rd++;
    end
    if (!started && prev == 4 && m_state == 4) begin
      m_left--;
      if (m_left == 0) begin
        m_state = 5;
        m_result = (model_sum() == 0) ? 2 : 3;
      end
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle; reads are compared to the model.
  task automatic bus(input bit wr, input bit rd, input logic [5:0] a, input logic [31:0] d,
                     input string tag);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    #1;
    if (rd) check(host_rdata, model_rd(a), tag);
    @(posedge clk);
    model_step(wr, rd, a, d);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
    bus(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    bus(1'b0, 1'b1, a, 32'h0, tag);
  endtask

  // Read with an extra literal expectation derived from the requirements.
  task automatic rd_exp(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1; host_addr = a; host_wdata = 0;
    #1;
    check(host_rdata, exp, tag);
    check(host_rdata, model_rd(a), tag);
    @(posedge clk);
    model_step(1'b0, 1'b1, a, 0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) rd(STS, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Build a payload of nwords with a correct checksum over len bytes.
  task automatic load_payload(input logic [31:0] cmd, input int len, input int nwords,
                              input logic [31:0] bias, input string tag);
    logic [31:0] w[$];
    logic [31:0] s = 0;
    for (int b = 0; b < 4; b++) s += 32'(cmd[8*b +: 8]);
    for (int i = 1; i < nwords; i++) begin
      w.push_back(32'h9E3779B9 * 32'(i) ^ 32'h1F2E3D4C);
      for (int b = 0; b < 4; b++)
        if (4*i + b < len) s += 32'(w[i-1][8*b +: 8]);
    end
    wr(CMD, cmd, tag);
    wr(LEN, 32'(len), tag);
    wr(DIN, (32'h0 - s) + bias, tag);
    for (int i = 0; i < nwords - 1; i++) wr(DIN, w[i], tag);
  endtask

  initial begin
    #(200000 * 4);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    m_state = 0; m_lock = 0; m_result = 0; m_rd = 0; m_left = 0;
    m_cmd = 0; m_len = 0; m_user = 0;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd_exp(STS, 32'h0, "R2 reset status");
    // R12: writes without the lock
    wr(CMD, 32'hDEAD0001, "R12");
    wr(EXEC, 32'h1, "R12");
    rd_exp(STS, 32'h0, "R12 status unchanged");
    rd_exp(CMD, 32'h0, "R12 cmd unchanged");

    // R1 acquisition
    rd_exp(LOCK, 32'h0, "R1 free lock read");
    rd_exp(STS, 32'h240, "R1 owned ready-for-command");
    rd_exp(LOCK, 32'h1, "R1 second lock read");
    rd_exp(STS, 32'h240, "R1 no change");
    wr(USER, 32'hA5A5_0003, "R3");
    rd_exp(USER, 32'hA5A5_0003, "R3 user readback");

    // R3/R8/R9/R13: full verify command, correct checksum
    wr(CMD, SIGCMD, "R3");
    rd_exp(STS, 32'h280, "R3 ready-for-length");
    rd_exp(CMD, SIGCMD, "R3 cmd readback");
    wr(LEN, 32'd196, "R3");
    rd_exp(STS, 32'h2C0, "R3 ready-for-data");
    m_state = 2; m_state = 3; // model already there; no-op realignment
    begin : good_payload
      logic [31:0] s = 0;
      for (int b = 0; b < 4; b++) s += 32'(SIGCMD[8*b +: 8]);
      for (int i = 1; i < 49; i++)
        for (int b = 0; b < 4; b++) s += 32'(((32'h9E3779B9 * 32'(i)) ^ 32'h1F2E3D4C) >> (8*b)) & 32'hFF;
      wr(DIN, 32'h0 - s, "R9");
      for (int i = 1; i < 49; i++) wr(DIN, (32'h9E3779B9 * 32'(i)) ^ 32'h1F2E3D4C, "R9");
    end
    rd_exp(LEN, 32'd196, "R3 length readback");
    wr(EXEC, 32'h1, "R8");
    rd_exp(STS, 32'h300, "R8 agent busy");
    rd_exp(EXEC, 32'h1, "R8 execute readback");
    idle(BUSY - 2, "R8");
    rd_exp(STS, 32'h342, "R9 complete");
    rd(DOUT, "R13 first word");
    rd(DOUT, "R13 second word");
    wr(EXEC, 32'h0, "R11");
    rd_exp(STS, 32'h0, "R11 released");
    rd_exp(LOCK, 32'h0, "R11 lock free again");

    // R9 failure: checksum off by one
    load_payload(SIGCMD, 196, 49, 32'h1, "R9");
    wr(EXEC, 32'h1, "R9");
    idle(BUSY, "R9");
    rd_exp(STS, 32'h343, "R9 failure result");
    rd(DOUT, "R13 restart after acquire");
    wr(UNLK, 32'h0, "R11");

    // R10 partial last word with junk in its upper bytes
    rd_exp(LOCK, 32'h0, "R10 acquire");
    begin : partial
      logic [31:0] s = 0;
      logic [31:0] w1 = 32'h11223344, w2 = 32'hFFEE5566;
      for (int b = 0; b < 4; b++) s += 32'(SIGCMD[8*b +: 8]) + 32'(w1[8*b +: 8]);
      s += 32'h66 + 32'h55;
      wr(CMD, SIGCMD, "R10");
      wr(LEN, 32'd10, "R10");
      wr(DIN, 32'h0 - s, "R10");
      wr(DIN, w1, "R10");
      wr(DIN, w2, "R10");
    end
    wr(EXEC, 32'h1, "R10");
    idle(BUSY, "R10");
    rd_exp(STS, 32'h342, "R10 masked bytes complete");
    rd(DOUT, "R13"); rd(DOUT, "R13"); rd(DOUT, "R13");
    rd_exp(DOUT, 32'h0, "R13 past last word");
    wr(EXEC, 32'h0, "R11");

    // R4 oversize length, then R14 stickiness
    rd(LOCK, "R4");
    wr(CMD, SIGCMD, "R4");
    wr(LEN, 32'(DEPTH*4 + 4), "R4");
    rd_exp(STS, 32'h380, "R4 oversize length error");
    wr(CMD, SIGCMD, "R14");
    wr(LEN, 32'd4, "R14");
    wr(EXEC, 32'h1, "R14");
    rd_exp(STS, 32'h380, "R14 error held");
    wr(UNLK, 32'h5, "R11");
    rd_exp(STS, 32'h0, "R11 leaves error");

    // R5 extra data push
    rd(LOCK, "R5");
    wr(CMD, 32'h1, "R5");
    wr(LEN, 32'd4, "R5");
    wr(DIN, 32'hFFFFFFFF, "R5");
    rd_exp(STS, 32'h2C0, "R5 still ready-for-data");
    wr(DIN, 32'h0, "R5");
    rd_exp(STS, 32'h380, "R5 push past length error");
    wr(EXEC, 32'h0, "R11");

    // R6 early execute
    rd(LOCK, "R6");
    wr(CMD, 32'h2, "R6");
    wr(LEN, 32'd8, "R6");
    wr(DIN, 32'h0, "R6");
    wr(EXEC, 32'h1, "R6");
    rd_exp(STS, 32'h380, "R6 early execute error");
    wr(EXEC, 32'h0, "R11");

    // R7 command written in data phase
    rd(LOCK, "R7");
    wr(CMD, 32'h3, "R7");
    wr(LEN, 32'd0, "R7");
    wr(CMD, 32'h4, "R7");
    rd_exp(STS, 32'h380, "R7 out-of-phase command error");
    rd_exp(CMD, 32'h3, "R7 command not overwritten");
    wr(UNLK, 32'h0, "R11");
    rd_exp(STS, 32'h0, "R11 final idle");

    @(negedge clk);
    host_wr = 0; host_rd = 0;
    finish_run();
  end

endmodule